// File: doc/BRIEF.md
# Eight-Level Nested Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output to a processor. A request register records rising edges on the lines. A mask register, written by software, gates those requests. A rotating-priority resolver picks the most urgent unmasked request. An in-service register records which levels the processor is handling now, so that a request of equal or lower priority waits until the handler finishes.

Software controls the block through a small write port. The address bit selects the command, and each command is an 8-bit word with fixed bit positions. These commands load the mask, end service on a level (specific, non-specific or rotating), move the priority base, switch special mask mode and choose which register a read returns. The processor acknowledges with two strobes. On the first strobe the controller commits its choice. On the second strobe it returns an 8-bit vector. The upper five vector bits come from the `VEC_BASE` parameter, and the low three bits are the level. The parameter `AUTO_EOI` makes in-service bits clear by themselves at the end of the acknowledge.

Top module: `irq_nested_ctrl`

## Requirements
- R1: A write with `addr_i`=1 loads the mask register from `wdata_i[7:0]`, with bit n masking level n. A masked level never raises `int_o`. A read with `addr_i`=1 returns the mask.
- R2: After reset the mask, request and in-service registers are zero and `int_o` is 0. Level 0 has the highest priority, special mask mode is off and a status read returns the request register.
- R3: A rising edge on `irq_req_i[n]` sets request bit n. The bit stays set until the first acknowledge strobe selects level n.
- R4: On the first strobe of `ack_i`, the winning level has its in-service bit set and its request bit cleared. During the second strobe, `vec_valid_o`=1 and `vector_o` = {`VEC_BASE[7:3]`, level}.
- R5: While a level is in service, requests of the same or lower priority keep `int_o` low, and a higher-priority request raises it.
- R6: Writing 0x20 at `addr_i`=0 (bits 7:5 = 001, bits 4:3 = 00) clears the highest-priority set in-service bit.
- R7: Writing 0x60|L at `addr_i`=0 clears in-service bit L only.
- R8: Writing 0xA0 clears the highest-priority in-service bit and makes that level the lowest priority. Writing 0xE0|L clears bit L and makes level L the lowest priority.
- R9: Writing 0xC0|L at `addr_i`=0 makes level L+1 (mod 8) the highest priority and changes no in-service bit.
- R10: A write at `addr_i`=0 with bits 4:3 = 01 and bit 7 = 0 is a mode word. 0x68 enters special mask mode, 0x48 leaves it, and 0x28 (bit 6 clear) leaves the mode unchanged. In special mask mode, an in-service level whose mask bit is set does not block other levels.
- R11: Mode word 0x0A selects the request register and 0x0B selects the in-service register for reads at `addr_i`=0. A mode word with bit 1 clear keeps the selection. A mode word with bit 7 set is ignored.
- R12: With `AUTO_EOI`=1, the in-service bit of the acknowledged level is clear on the cycle after the second strobe.
- R13: A first strobe while `int_o`=0 sets no in-service bit and clears no request bit. The second strobe then returns level 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 8 | Interrupt request lines, edge sensed |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Command select / read select |
| wdata_i | input | 8 | Command word |
| rdata_o | output | 8 | Readback: mask, request or in-service register |
| int_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | Acknowledge strobe; consecutive strobes alternate first/second |
| vector_o | output | 8 | Vector during the second strobe |
| vec_valid_o | output | 1 | High while `vector_o` is valid |

## Verification
The bench raises a lower level while a higher level is in service and checks that `int_o` stays low. A design that compares priority with the wrong sign would interrupt the handler at once. It rotates the priority base and then posts two requests together; a resolver that ignores the base would return the fixed-order winner. It puts a masked level in service and toggles special mask mode, including a mode word with bit 6 clear that must change nothing; mishandling that bit would release or block the lower level at the wrong time. It also checks that an acknowledge with nothing pending leaves the in-service register empty, and it uses a second instance with automatic end-of-interrupt to see the in-service bit clear without a command.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int DATA_W  = 8;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic mask_we;
    logic eoi_ns;    // clear highest in-service level
    logic eoi_sp;    // clear selected level
    logic rot;       // rotate with eoi
    logic set_prio;
    logic smm_we;
    logic smm_val;
    logic rsel_we;
    logic rsel_val;  // 1: in-service, 0: request
    lvl_t lvl;
  } cmd_t;
endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_pkg::*;
#(
  parameter int N = NUM_LVL,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] base_i,
  output logic         found_o,
  output logic [W-1:0] lvl_o
);
  // scan from lowest priority to highest so the last hit wins
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = (k + int'(base_i)) % N;
      if (vec_i[idx]) begin
        found_o = 1'b1;
        lvl_o   = W'(idx);
      end
    end
  end
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_pkg::*;
(
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cmd_t              cmd_o
);
  logic is_eoi_word, is_mode_word;

  assign is_eoi_word  = wr_en_i && !addr_i && (wdata_i[4:3] == 2'b00);
  assign is_mode_word = wr_en_i && !addr_i && (wdata_i[4:3] == 2'b01) && !wdata_i[7];

  always_comb begin
    cmd_o          = '0;
    cmd_o.mask_we  = wr_en_i && addr_i;
    cmd_o.lvl      = wdata_i[LVL_W-1:0];
    cmd_o.eoi_ns   = is_eoi_word && wdata_i[5] && !wdata_i[6];
    cmd_o.eoi_sp   = is_eoi_word && wdata_i[5] &&  wdata_i[6];
    cmd_o.rot      = is_eoi_word && wdata_i[7] &&  wdata_i[5];
    cmd_o.set_prio = is_eoi_word && wdata_i[7] &&  wdata_i[6] && !wdata_i[5];
    cmd_o.smm_we   = is_mode_word && wdata_i[6];
    cmd_o.smm_val  = wdata_i[5];
    cmd_o.rsel_we  = is_mode_word && wdata_i[1];
    cmd_o.rsel_val = wdata_i[0];
  end
endmodule

// File: rtl/irq_nested_ctrl.sv
module irq_nested_ctrl
  import irq_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h20,
  parameter int                AUTO_EOI = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LVL-1:0] irq_req_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              int_o,
  input  logic              ack_i,
  output logic [DATA_W-1:0] vector_o,
  output logic              vec_valid_o
);
  logic [NUM_LVL-1:0] req_q, irr_q, imr_q, isr_q;
  logic [NUM_LVL-1:0] irr_d, isr_d, isr_set, isr_clr, irr_clr;
  logic [NUM_LVL-1:0] cand, blk;
  lvl_t base_q, base_d, sel_lvl_q;
  logic smm_q, rsel_q, ack_ph_q, sel_ok_q;
  logic ack1, ack2;
  cmd_t cmd;

  logic p_found, s_found, e_found;
  lvl_t p_lvl, s_lvl, e_lvl, p_rank, s_rank;

  irq_cmd_decode u_dec (
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .cmd_o(cmd)
  );

  assign cand = smm_q ? (irr_q & ~imr_q & ~isr_q) : (irr_q & ~imr_q);
  assign blk  = smm_q ? (isr_q & ~imr_q) : isr_q;

  irq_prio_resolver #(.N(NUM_LVL)) u_pend (
    .vec_i(cand), .base_i(base_q), .found_o(p_found), .lvl_o(p_lvl)
  );
  irq_prio_resolver #(.N(NUM_LVL)) u_blk (
    .vec_i(blk), .base_i(base_q), .found_o(s_found), .lvl_o(s_lvl)
  );
  irq_prio_resolver #(.N(NUM_LVL)) u_eoi (
    .vec_i(isr_q), .base_i(base_q), .found_o(e_found), .lvl_o(e_lvl)
  );

  // rank 0 is the level at the rotating base
  assign p_rank = p_lvl - base_q;
  assign s_rank = s_lvl - base_q;
  assign int_o  = p_found && (!s_found || (p_rank < s_rank));

  assign ack1 = ack_i && !ack_ph_q;
  assign ack2 = ack_i &&  ack_ph_q;

  always_comb begin
    isr_set = '0;
    irr_clr = '0;
    isr_clr = '0;
    base_d  = base_q;
    if (ack1 && int_o) begin
      isr_set = NUM_LVL'(1) << p_lvl;
      irr_clr = NUM_LVL'(1) << p_lvl;
    end
    if (cmd.eoi_ns && e_found) begin
      isr_clr = isr_clr | (NUM_LVL'(1) << e_lvl);
      if (cmd.rot) base_d = e_lvl + lvl_t'(1);
    end
    if (cmd.eoi_sp) begin
      isr_clr = isr_clr | (NUM_LVL'(1) << cmd.lvl);
      if (cmd.rot) base_d = cmd.lvl + lvl_t'(1);
    end
    if (cmd.set_prio) base_d = cmd.lvl + lvl_t'(1);
    if ((AUTO_EOI != 0) && ack2 && sel_ok_q)
      isr_clr = isr_clr | (NUM_LVL'(1) << sel_lvl_q);
  end

  assign irr_d = (irr_q & ~irr_clr) | (irq_req_i & ~req_q);
  assign isr_d = (isr_q & ~isr_clr) | isr_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      irr_q     <= '0;
      imr_q     <= '0;
      isr_q     <= '0;
      base_q    <= '0;
      smm_q     <= 1'b0;
      rsel_q    <= 1'b0;
      ack_ph_q  <= 1'b0;
      sel_lvl_q <= '0;
      sel_ok_q  <= 1'b0;
    end else begin
      req_q  <= irq_req_i;
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      base_q <= base_d;
      if (cmd.mask_we) imr_q  <= wdata_i;
      if (cmd.smm_we)  smm_q  <= cmd.smm_val;
      if (cmd.rsel_we) rsel_q <= cmd.rsel_val;
      if (ack_i) ack_ph_q <= !ack_ph_q;
      if (ack1) begin
        sel_ok_q  <= int_o;
        sel_lvl_q <= int_o ? p_lvl : lvl_t'(NUM_LVL - 1);
      end
    end
  end

  assign rdata_o     = addr_i ? imr_q : (rsel_q ? isr_q : irr_q);
  assign vec_valid_o = ack2;
  assign vector_o    = ack2 ? {VEC_BASE[DATA_W-1:LVL_W], sel_lvl_q} : '0;

  // ---------------- assertions ----------------
  assert_int_needs_unmasked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_q & ~imr_q));

  assert_ack_sets_isr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack1 && int_o) |=> isr_q[$past(p_lvl)]);

  assert_spec_eoi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.eoi_sp && !ack_i) |=> !isr_q[$past(cmd.lvl)]);

  assert_smm_unchanged_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[4:3] == 2'b01 && !wdata_i[6]) |=> $stable(smm_q));

  assert_auto_eoi_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((AUTO_EOI != 0) && ack2) |=> !isr_q[$past(sel_lvl_q)]);
endmodule

// File: tb/irq_nested_ctrl_tb.sv
module irq_nested_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec, rdata_a, vec_a;
  logic       int_w, vval, int_a, vval_a;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  irq_nested_ctrl #(.VEC_BASE(8'h20), .AUTO_EOI(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .int_o(int_w), .ack_i(ack),
    .vector_o(vec), .vec_valid_o(vval));

  irq_nested_ctrl #(.VEC_BASE(8'h20), .AUTO_EOI(1)) dut_aeoi_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .int_o(int_a), .ack_i(ack),
    .vector_o(vec_a), .vec_valid_o(vval_a));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp_vec);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); #1;
    chk(req, {7'b0, vval}, 8'h01);
    chk(req, vec, exp_vec);
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic int_is(input string req, input logic exp);
    @(negedge clk); #1 chk(req, {7'b0, int_w}, {7'b0, exp});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    int_is("R2 int", 1'b0);
    rd(1'b1, v); chk("R2 mask", v, 8'h00);
    rd(1'b0, v); chk("R2 irr", v, 8'h00);
  endtask

  task automatic t_auto_eoi;
    logic [7:0] v;
    wr(1'b0, 8'h0B);
    pulse(8'h10);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); #1 chk("R12 aeoi vector", vec_a, 8'h24);
    @(negedge clk); ack = 1'b0;
    rd(1'b0, v);
    chk("R12 aeoi isr clear", rdata_a, 8'h00);
    chk("R12 normal isr held", v, 8'h10);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_mask_and_ack;
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R1 mask readback", v, 8'hFF);
    pulse(8'h08);
    int_is("R1 masked no int", 1'b0);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R3 irr latched", v, 8'h08);
    wr(1'b1, 8'h00);
    int_is("R1 unmasked int", 1'b1);
    do_ack("R4 vector lvl3", 8'h23);
    rd(1'b0, v); chk("R3 irr cleared on ack", v, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R4 isr set", v, 8'h08);
  endtask

  task automatic t_nesting;
    logic [7:0] v;
    pulse(8'h20);
    int_is("R5 lower blocked", 1'b0);
    pulse(8'h02);
    int_is("R5 higher passes", 1'b1);
    do_ack("R5 vector lvl1", 8'h21);
    rd(1'b0, v); chk("R5 isr nested", v, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R6 nonspecific eoi", v, 8'h08);
    int_is("R5 still blocked", 1'b0);
    wr(1'b0, 8'h63);
    rd(1'b0, v); chk("R7 specific eoi", v, 8'h00);
    int_is("R7 released", 1'b1);
    do_ack("R4 vector lvl5", 8'h25);
    wr(1'b0, 8'h65);
  endtask

  task automatic t_rotate;
    logic [7:0] v;
    pulse(8'h04);
    do_ack("R8 vector lvl2", 8'h22);
    wr(1'b0, 8'hA0);
    rd(1'b0, v); chk("R8 rotate eoi clears", v, 8'h00);
    pulse(8'h14);
    do_ack("R8 rotated winner", 8'h24);
    int_is("R8 lvl2 now lowest", 1'b0);
    wr(1'b0, 8'h64);
    do_ack("R8 lvl2 after", 8'h22);
    wr(1'b0, 8'h62);
    wr(1'b0, 8'hC5);
    rd(1'b0, v); chk("R9 isr untouched", v, 8'h00);
    pulse(8'h81);
    do_ack("R9 lvl7 highest", 8'h27);
    wr(1'b0, 8'h67);
    do_ack("R9 lvl0 next", 8'h20);
    wr(1'b0, 8'h60);
    wr(1'b0, 8'hC7);
  endtask

  task automatic t_special_mask;
    pulse(8'h08);
    do_ack("R10 vector lvl3", 8'h23);
    wr(1'b1, 8'h08);
    pulse(8'h40);
    int_is("R10 normal blocks", 1'b0);
    wr(1'b0, 8'h28);
    int_is("R10 esmm=0 ignored", 1'b0);
    wr(1'b0, 8'h68);
    int_is("R10 smm releases", 1'b1);
    wr(1'b0, 8'h48);
    int_is("R10 smm left", 1'b0);
    wr(1'b0, 8'h68);
    do_ack("R10 vector lvl6", 8'h26);
    wr(1'b0, 8'h48);
    wr(1'b0, 8'h66);
    wr(1'b0, 8'h63);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_readsel_spurious;
    logic [7:0] v;
    wr(1'b1, 8'h80);
    pulse(8'h80);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R11 irr select", v, 8'h80);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R11 isr select", v, 8'h00);
    wr(1'b0, 8'h08);
    rd(1'b0, v); chk("R11 rr=0 keeps", v, 8'h00);
    wr(1'b0, 8'h8A);
    rd(1'b0, v); chk("R11 d7 ignored", v, 8'h00);
    int_is("R13 nothing to serve", 1'b0);
    do_ack("R13 spurious vector", 8'h27);
    rd(1'b0, v); chk("R13 isr empty", v, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R13 irr kept", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_auto_eoi();
    t_mask_and_ack();
    t_nesting();
    t_rotate();
    t_special_mask();
    t_readsel_spurious();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule